// File: doc/BRIEF.md
# Instruction Breakpoint Comparator Slot

This block is a single breakpoint slot for a processor's debug logic. Software programs it through a small register port with a 64-bit control word and a 64-bit value word. Each cycle it compares the address of a retiring instruction, or the current context identifier and virtual machine identifier, against the value word. When the programmed rule is met it raises a registered hit.

The slot supports several comparison modes:
- exact word or halfword address match;
- address mismatch, which is the inverse of a match and is used for stepping;
- power-of-two address ranges set by a low-bit mask;
- context identifier, VMID, or combined context and VMID comparison.

A context slot that has linking enabled does not raise its own hit. Instead it exports its comparison result on `ctx_link_out`. An address slot of a linked type takes the exported results of all slots on `peer_ctx_hit` and qualifies its own result with the entry named by its link number. Filtering by privilege and security state is left to surrounding logic. The fields for those filters are only stored and read back.

Top module: `brk_slot`

## Requirements
- R1: When the enable field (control bit 0) is 0, `bp_hit` stays low whatever the other fields and inputs are.
- R2: After reset `bp_hit` is 0 and both the control word (`reg_sel`=0) and the value word (`reg_sel`=1) read as zero.
- R3: Type code 0000 (control bits 23:20) with lane select 1111 (bits 8:5) hits when the instruction address equals the value word with bits 1:0 of both ignored, so either halfword of the word matches.
- R4: With type 0000, lane select 0011 hits only when address bit 1 is 0, and lane select 1100 hits only when address bit 1 is 1. The upper address bits must also match.
- R5: Type 0100 hits exactly when the type-0000 comparison with the same settings would not hit. With lane select 0000 it hits on every valid instruction.
- R6: A mask value M from 3 to 31 (control bits 28:24) ignores address bits M-1:0 in the comparison, and the lane select is not used. Mask 0 means no masking.
- R7: Mask value 1 or 2, or a nonzero mask M with any of value bits M-1:0 set, makes the slot behave as disabled.
- R8: Type 0010 hits when value bits 31:0 equal `cur_ctx`. Type 1000 hits when value bits 47:32 equal `cur_vmid`. Type 1010 hits only when both comparisons hold.
- R9: The linkable context types 0011, 1001 and 1011 never raise `bp_hit`. They drive `ctx_link_out` high while their comparison (as in R8) holds. All other types hold `ctx_link_out` low.
- R10: Types 0001 and 0101 behave as 0000 and 0100 but hit only if `peer_ctx_hit[L]` is 1, where L is the link number in control bits 19:16.
- R11: Type codes 0110, 0111 and 11xx, and any type with the extension bit (control bit 3) set, never hit.
- R12: The control word reads back bit 0, bits 3:1, bits 8:5, bit 13, bits 15:14, bits 19:16, bits 23:20 and bits 28:24 as written. All other bits read as 0. Bits 8:5 read as 1111 when type bit 3 or type bit 1 is set. The value word reads back all 64 bits.
- R13: `bp_hit` rises one clock after a cycle in which `instr_vld` is high and the rule holds, and it is low after a cycle without `instr_vld`. A register write is used from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the control word, 1 selects the value word |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data of the selected word |
| instr_vld | input | 1 | A retiring instruction is presented |
| instr_pc | input | ADDR_W | Address of the retiring instruction |
| cur_ctx | input | CTX_W | Current context identifier |
| cur_vmid | input | VMID_W | Current virtual machine identifier |
| peer_ctx_hit | input | NSLOT | Link outputs of all slots, indexed by slot number |
| ctx_link_out | output | 1 | This slot's context result for linked slots |
| bp_hit | output | 1 | Registered breakpoint hit |

## Verification
The assertions assume that `rst_n` is held low from time zero until the first clock edges have passed. They also assume that the register port changes a word only through `reg_we`. Some properties relate the stored fields of one cycle to `bp_hit` in the next, so they rely on every input being stable around the clock edge. The stimulus follows this by driving all inputs on the falling edge. It also changes register contents only through the write strobe, so every stored field seen at a rising edge is the one the hit logic used.

// File: rtl/brk_slot.sv
module brk_slot #(
  parameter int ADDR_W = 64,
  parameter int CTX_W  = 32,
  parameter int VMID_W = 16,
  parameter int NSLOT  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_sel,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  input  logic              instr_vld,
  input  logic [ADDR_W-1:0] instr_pc,
  input  logic [CTX_W-1:0]  cur_ctx,
  input  logic [VMID_W-1:0] cur_vmid,
  input  logic [NSLOT-1:0]  peer_ctx_hit,
  output logic              ctx_link_out,
  output logic              bp_hit
);
  localparam int VM_LO = 32;
  localparam int VM_HI = VM_LO + VMID_W - 1;

  logic       en_q, bt2_q, hmc_q;
  logic [1:0] pmc_q, ssc_q;
  logic [3:0] bas_q, lbn_q, bt_q;
  logic [4:0] mask_q;
  logic [63:0] val_q;
  logic       hit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      pmc_q  <= '0;
      bt2_q  <= 1'b0;
      bas_q  <= '0;
      hmc_q  <= 1'b0;
      ssc_q  <= '0;
      lbn_q  <= '0;
      bt_q   <= '0;
      mask_q <= '0;
      val_q  <= '0;
    end else if (reg_we) begin
      if (!reg_sel) begin
        en_q   <= reg_wdata[0];
        pmc_q  <= reg_wdata[2:1];
        bt2_q  <= reg_wdata[3];
        bas_q  <= reg_wdata[8:5];
        hmc_q  <= reg_wdata[13];
        ssc_q  <= reg_wdata[15:14];
        lbn_q  <= reg_wdata[19:16];
        bt_q   <= reg_wdata[23:20];
        mask_q <= reg_wdata[28:24];
      end else begin
        val_q  <= reg_wdata;
      end
    end
  end

  logic [3:0] bas_rd;
  assign bas_rd = (bt_q[3] | bt_q[1]) ? 4'hF : bas_q;

  assign reg_rdata = reg_sel ? val_q :
    {32'b0, 3'b0, mask_q, bt_q, lbn_q, ssc_q, hmc_q, 4'b0, bas_rd, 1'b0, bt2_q, pmc_q, en_q};

  logic [ADDR_W-1:0] low_ones, keep;
  logic mask_rsvd, under_set, live;
  assign low_ones  = (ADDR_W'(1) << mask_q) - ADDR_W'(1);
  assign keep      = (mask_q == 5'd0) ? ~ADDR_W'(3) : ~low_ones;
  assign mask_rsvd = (mask_q == 5'd1) || (mask_q == 5'd2);
  assign under_set = (mask_q != 5'd0) && (|(val_q[ADDR_W-1:0] & low_ones));
  assign live      = en_q && !mask_rsvd && !under_set;

  logic addr_eq, lane_ok, addr_hit;
  assign addr_eq  = ((instr_pc ^ val_q[ADDR_W-1:0]) & keep) == '0;
  assign lane_ok  = (mask_q != 5'd0) | bas_q[{instr_pc[1], 1'b0}];
  assign addr_hit = addr_eq & lane_ok;

  logic is_addr, invert, need_link, use_ctx, use_vm, ctx_self, ctx_lnk;
  always_comb begin
    is_addr = 1'b0; invert = 1'b0; need_link = 1'b0;
    use_ctx = 1'b0; use_vm = 1'b0; ctx_self = 1'b0; ctx_lnk = 1'b0;
    if (!bt2_q) begin
      case (bt_q)
        4'b0000: is_addr = 1'b1;
        4'b0001: begin is_addr = 1'b1; need_link = 1'b1; end
        4'b0100: begin is_addr = 1'b1; invert = 1'b1; end
        4'b0101: begin is_addr = 1'b1; invert = 1'b1; need_link = 1'b1; end
        4'b0010: begin use_ctx = 1'b1; ctx_self = 1'b1; end
        4'b0011: begin use_ctx = 1'b1; ctx_lnk = 1'b1; end
        4'b1000: begin use_vm = 1'b1; ctx_self = 1'b1; end
        4'b1001: begin use_vm = 1'b1; ctx_lnk = 1'b1; end
        4'b1010: begin use_ctx = 1'b1; use_vm = 1'b1; ctx_self = 1'b1; end
        4'b1011: begin use_ctx = 1'b1; use_vm = 1'b1; ctx_lnk = 1'b1; end
        default: ;
      endcase
    end
  end

  logic ctx_eq, link_ok, addr_cond, fire;
  assign ctx_eq    = (!use_ctx || (val_q[CTX_W-1:0] == cur_ctx)) &&
                     (!use_vm  || (val_q[VM_HI:VM_LO] == cur_vmid));
  assign link_ok   = !need_link || peer_ctx_hit[lbn_q];
  assign addr_cond = (addr_hit ^ invert) & link_ok;
  assign fire      = live & ((is_addr & addr_cond) | (ctx_self & ctx_eq));

  assign ctx_link_out = live & ctx_lnk & ctx_eq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= instr_vld & fire;
  end

  assign bp_hit = hit_q;
endmodule

module brk_slot_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        en,
  input logic        bt2,
  input logic [3:0]  bt,
  input logic [4:0]  mask,
  input logic        instr_vld,
  input logic        reg_sel,
  input logic [63:0] reg_rdata,
  input logic        ctx_link_out,
  input logic        bp_hit
);
  a_r1_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !bp_hit);

  a_r13_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_vld |=> !bp_hit);

  a_r7_bad_mask_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == 5'd1 || mask == 5'd2) |=> !bp_hit);

  a_r9_link_type_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!bt2 && (bt == 4'b0011 || bt == 4'b1001 || bt == 4'b1011)) |=> !bp_hit);

  a_r9_link_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_link_out |-> en);

  a_r11_ext_bit_silent: assert property (@(posedge clk) disable iff (!rst_n)
    bt2 |=> !bp_hit);

  a_r12_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_sel |-> (reg_rdata[63:32] == 32'b0));
endmodule

bind brk_slot brk_slot_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en_q), .bt2(bt2_q), .bt(bt_q), .mask(mask_q),
  .instr_vld(instr_vld), .reg_sel(reg_sel), .reg_rdata(reg_rdata),
  .ctx_link_out(ctx_link_out), .bp_hit(bp_hit)
);

// File: tb/tb_brk_slot.sv
module tb_brk_slot;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0, reg_sel = 1'b0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        instr_vld = 1'b0;
  logic [63:0] instr_pc = '0;
  logic [31:0] cur_ctx = '0;
  logic [15:0] cur_vmid = '0;
  logic [15:0] peer_ctx_hit = '0;
  logic        ctx_link_out, bp_hit;

  int nchk = 0, nfail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  brk_slot dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .instr_vld(instr_vld),
    .instr_pc(instr_pc), .cur_ctx(cur_ctx), .cur_vmid(cur_vmid),
    .peer_ctx_hit(peer_ctx_hit), .ctx_link_out(ctx_link_out), .bp_hit(bp_hit)
  );

  typedef struct packed {
    logic [31:0] c;
    logic [63:0] v;
    logic [63:0] pc;
    logic [31:0] cx;
    logic [15:0] vm;
    logic [15:0] pr;
    logic [3:0]  rq;
    logic        e;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VT [NV] = '{
    '{32'h000001E0, 64'h1000, 64'h1000, 32'h0, 16'h0, 16'h0, 4'd1, 1'b0},   // R1
    '{32'h000001E1, 64'h1000, 64'h1000, 32'h0, 16'h0, 16'h0, 4'd3, 1'b1},   // R3
    '{32'h000001E1, 64'h1000, 64'h1002, 32'h0, 16'h0, 16'h0, 4'd3, 1'b1},
    '{32'h000001E1, 64'h1000, 64'h1004, 32'h0, 16'h0, 16'h0, 4'd3, 1'b0},
    '{32'h000001E1, 64'h1003, 64'h1000, 32'h0, 16'h0, 16'h0, 4'd3, 1'b1},
    '{32'h00000061, 64'h1000, 64'h1000, 32'h0, 16'h0, 16'h0, 4'd4, 1'b1},   // R4
    '{32'h00000061, 64'h1000, 64'h1002, 32'h0, 16'h0, 16'h0, 4'd4, 1'b0},
    '{32'h00000181, 64'h1000, 64'h1002, 32'h0, 16'h0, 16'h0, 4'd4, 1'b1},
    '{32'h00000181, 64'h1000, 64'h1000, 32'h0, 16'h0, 16'h0, 4'd4, 1'b0},
    '{32'h004001E1, 64'h1000, 64'h1000, 32'h0, 16'h0, 16'h0, 4'd5, 1'b0},   // R5
    '{32'h004001E1, 64'h1000, 64'h2000, 32'h0, 16'h0, 16'h0, 4'd5, 1'b1},
    '{32'h00400001, 64'h1000, 64'h1000, 32'h0, 16'h0, 16'h0, 4'd5, 1'b1},
    '{32'h0C0001E1, 64'h5000, 64'h5FFC, 32'h0, 16'h0, 16'h0, 4'd6, 1'b1},   // R6
    '{32'h0C0001E1, 64'h5000, 64'h6000, 32'h0, 16'h0, 16'h0, 4'd6, 1'b0},
    '{32'h0C0001E1, 64'h5000, 64'h4FFC, 32'h0, 16'h0, 16'h0, 4'd6, 1'b0},
    '{32'h030001E1, 64'h1008, 64'h100C, 32'h0, 16'h0, 16'h0, 4'd6, 1'b1},
    '{32'h0C0001E1, 64'h5800, 64'h5800, 32'h0, 16'h0, 16'h0, 4'd7, 1'b0},   // R7
    '{32'h010001E1, 64'h1000, 64'h1000, 32'h0, 16'h0, 16'h0, 4'd7, 1'b0},
    '{32'h020001E1, 64'h1000, 64'h1000, 32'h0, 16'h0, 16'h0, 4'd7, 1'b0},
    '{32'h00200001, 64'hCAFE, 64'h0, 32'hCAFE, 16'h0, 16'h0, 4'd8, 1'b1},   // R8
    '{32'h00200001, 64'hCAFE, 64'h0, 32'hCAFF, 16'h0, 16'h0, 4'd8, 1'b0},
    '{32'h00800001, 64'h0000_0005_0000_0000, 64'h0, 32'h0, 16'h5, 16'h0, 4'd8, 1'b1},
    '{32'h00800001, 64'h0000_0005_0000_0000, 64'h0, 32'h0, 16'h6, 16'h0, 4'd8, 1'b0},
    '{32'h00A00001, 64'h0000_0005_0000_CAFE, 64'h0, 32'hCAFE, 16'h5, 16'h0, 4'd8, 1'b1},
    '{32'h00A00001, 64'h0000_0005_0000_CAFE, 64'h0, 32'hCAFE, 16'h6, 16'h0, 4'd8, 1'b0},
    '{32'h00300001, 64'hCAFE, 64'h0, 32'hCAFE, 16'h0, 16'h0, 4'd9, 1'b0},   // R9
    '{32'h001301E1, 64'h1000, 64'h1000, 32'h0, 16'h0, 16'h0008, 4'd10, 1'b1}, // R10
    '{32'h001301E1, 64'h1000, 64'h1000, 32'h0, 16'h0, 16'h0004, 4'd10, 1'b0},
    '{32'h001301E1, 64'h1000, 64'h1004, 32'h0, 16'h0, 16'h0008, 4'd10, 1'b0},
    '{32'h005201E1, 64'h1000, 64'h2000, 32'h0, 16'h0, 16'h0004, 4'd10, 1'b1},
    '{32'h005201E1, 64'h1000, 64'h2000, 32'h0, 16'h0, 16'h0000, 4'd10, 1'b0},
    '{32'h00600001, 64'hCAFE, 64'h0, 32'hCAFE, 16'h0, 16'h0, 4'd11, 1'b0},  // R11
    '{32'h000001E9, 64'h1000, 64'h1000, 32'h0, 16'h0, 16'h0, 4'd11, 1'b0},
    '{32'h00C00001, 64'hCAFE, 64'h0, 32'hCAFE, 16'h0, 16'h0, 4'd11, 1'b0}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [63:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic sel, input logic [63:0] exp);
    reg_sel = sel;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2 reset state
    chk("R2 hit", {63'b0, bp_hit}, 64'd0);
    rd("R2 ctrl", 1'b0, 64'd0);
    rd("R2 value", 1'b1, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      wr(1'b0, {32'b0, VT[i].c});
      wr(1'b1, VT[i].v);
      instr_vld = 1'b1; instr_pc = VT[i].pc; cur_ctx = VT[i].cx;
      cur_vmid = VT[i].vm; peer_ctx_hit = VT[i].pr;
      @(negedge clk);
      instr_vld = 1'b0;
      chk($sformatf("R%0d vector %0d", VT[i].rq, i), {63'b0, bp_hit}, {63'b0, VT[i].e});
    end

    // R12 read-back layout
    wr(1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
    rd("R12 all ones", 1'b0, 64'h0000_0000_1FFF_E1EF);
    wr(1'b0, 64'h0020_0001);
    rd("R12 ctx lanes", 1'b0, 64'h0000_0000_0020_01E1);
    wr(1'b0, 64'h61);
    rd("R12 addr lanes", 1'b0, 64'h61);
    wr(1'b1, 64'hDEAD_BEEF_0123_4567);
    rd("R12 value", 1'b1, 64'hDEAD_BEEF_0123_4567);

    // R9 link output
    wr(1'b0, 64'h0030_0001);
    wr(1'b1, 64'hCAFE);
    cur_ctx = 32'hCAFE; #1;
    chk("R9 link out match", {63'b0, ctx_link_out}, 64'd1);
    cur_ctx = 32'hCAFF; #1;
    chk("R9 link out miss", {63'b0, ctx_link_out}, 64'd0);
    wr(1'b0, 64'h0020_0001);
    cur_ctx = 32'hCAFE; #1;
    chk("R9 unlinked no link out", {63'b0, ctx_link_out}, 64'd0);

    // R13 timing
    wr(1'b0, 64'h1E1);
    wr(1'b1, 64'h1000);
    instr_pc = 64'h1000; peer_ctx_hit = '0;
    @(negedge clk);
    chk("R13 no valid no hit", {63'b0, bp_hit}, 64'd0);
    wr(1'b0, 64'h1E0);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = 1'b0; reg_wdata = 64'h1E1; instr_vld = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
    chk("R13 write not yet used", {63'b0, bp_hit}, 64'd0);
    @(negedge clk);
    instr_vld = 1'b0;
    chk("R13 write used next cycle", {63'b0, bp_hit}, 64'd1);
    @(negedge clk);
    chk("R13 hit drops", {63'b0, bp_hit}, 64'd0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule